// File: doc/BRIEF.md
# Multi-Page-Size TLB Lookup Sequencer

This block translates a virtual address and a 16-bit address-space identifier into a physical address. It holds two translation caches. The first is a small fully-associative front cache that is searched in full on every request. The second is a larger set-associative back cache with four ways per set. Every entry in either cache records its own page size: 4 KiB, 2 MiB or 1 GiB. The tag compare ignores the virtual page bits that fall inside that page's offset, and it always includes the identifier.

When the front cache misses, the sequencer searches the back cache one page size per cycle. It uses a set index taken from the bits just above the offset of that size, and tries 4 KiB first, then 2 MiB, then 1 GiB. A back-cache hit is copied into the front cache. If all three searches miss, the sequencer raises a walk request to an external table walker. The walker's answer is written into both caches and also returned to the requester.

Requests, responses and walk requests use valid/ready handshakes. Only one translation is in flight at a time: `req_ready` is high only while the block is idle. A response stays valid and stable until `rsp_ready` is seen. A walk request stays valid and stable until `walk_ready` is seen. The fill from the walker is taken on any cycle in which both `fill_valid` and `fill_ready` are high.

Top module: `tlb_lookup_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `walk_valid` and `fill_ready` are 0. Both caches start empty, so the first lookup raises a walk request.
- R2: From the edge that accepts a request until the edge that accepts its response, `req_ready` stays 0.
- R3: On a front-cache hit, `rsp_valid` rises at the first clock edge after the accepting edge.
- R4: On a front-cache miss, the back cache is searched one size per cycle, in the order 4 KiB, 2 MiB, 1 GiB. A hit of each size raises `rsp_valid` at the 2nd, 3rd or 4th edge after acceptance, respectively.
- R5: When all three searches miss, `walk_valid` rises at the 4th edge after acceptance. `walk_va` and `walk_asid` equal the request. Both stay stable until `walk_ready` is seen.
- R6: After the walk handshake, `fill_ready` is 1. The accepted fill produces a response at the next edge and is installed in both caches.
- R7: A back-cache hit is copied into the front cache, so an immediate repeat of that lookup hits with the R3 latency.
- R8: The size codes on `fill_size` and `rsp_size` are 0 = 4 KiB, 1 = 2 MiB and 2 = 1 GiB. `rsp_pa` takes the low 12, 21 or 30 bits from the virtual address and the bits above them from the stored frame number.
- R9: An entry matches only when its identifier equals `req_asid`. The same address under a different identifier misses and walks.
- R10: The front cache holds `UTLB_N` entries and replaces them round-robin. After `UTLB_N` further installs, an entry is gone from it.
- R11: Each back-cache set replaces its ways round-robin. The set index is va[15:12] for 4 KiB, va[24:21] for 2 MiB and va[33:30] for 1 GiB (16 sets).
- R12: While `rsp_ready` is 0, `rsp_valid`, `rsp_pa` and `rsp_size` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 39 | Virtual address |
| req_asid | input | 16 | Address-space identifier |
| rsp_valid | output | 1 | Translation valid |
| rsp_ready | input | 1 | Requester takes translation |
| rsp_pa | output | 40 | Physical address |
| rsp_size | output | 2 | Page size code of the translation |
| walk_valid | output | 1 | Table walk requested |
| walk_ready | input | 1 | Walker accepts request |
| walk_va | output | 39 | Address to walk |
| walk_asid | output | 16 | Identifier to walk |
| fill_valid | input | 1 | Walker result valid |
| fill_ready | output | 1 | Block waits for walker result |
| fill_ppn | input | 28 | Physical frame number from walker |
| fill_size | input | 2 | Page size code from walker |

## Verification
The checker assumes the walker never drives size code 3. It also assumes `fill_valid` is asserted only after a walk was accepted. The bench stub answers exactly once per accepted walk and only with the three legal codes. The design also relies on the translations for one identifier never overlapping, such as a 4 KiB page inside a mapped 2 MiB page, because overlapping hits would be resolved by priority alone. The stimulus keeps every mapped page disjoint and places the pages in chosen sets, so that set pressure arises only where a replacement test wants it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int OFF_W  = 12;
  localparam int LVL_W  = 9;
  localparam int VA_W   = 39;
  localparam int PA_W   = 40;
  localparam int ASID_W = 16;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef struct packed {
    logic                vld;
    pg_size_e            size;
    logic [ASID_W-1:0]   asid;
    logic [VPN_W-1:0]    vpn;
    logic [PPN_W-1:0]    ppn;
  } tlb_ent_t;

  // VPN bits that take part in the compare for a page of this size
  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
    case (s)
      PG_2M:   return {{(VPN_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};
      PG_1G:   return {{(VPN_W-2*LVL_W){1'b1}}, {(2*LVL_W){1'b0}}};
      default: return {VPN_W{1'b1}};
    endcase
  endfunction

  function automatic logic ent_hit(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                   logic [ASID_W-1:0] asid);
    return e.vld && (e.asid == asid) &&
           (((e.vpn ^ vpn) & vpn_mask(e.size)) == '0);
  endfunction

  function automatic logic [PA_W-1:0] xlate(tlb_ent_t e, logic [VA_W-1:0] va);
    logic [PA_W-1:0] keep;
    case (e.size)
      PG_2M:   keep = PA_W'({(OFF_W+LVL_W){1'b1}});
      PG_1G:   keep = PA_W'({(OFF_W+2*LVL_W){1'b1}});
      default: keep = PA_W'({OFF_W{1'b1}});
    endcase
    return ({e.ppn, {OFF_W{1'b0}}} & ~keep) |
           ({{(PA_W-VA_W){1'b0}}, va} & keep);
  endfunction
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr <= '0;
    else if (adv) begin
      if (ptr == PW'(N-1))      ptr <= '0;
      else                      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_micro.sv
module tlb_micro
  import tlb_pkg::*;
#(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output tlb_ent_t          hit_ent,
  input  logic              wr_en,
  input  tlb_ent_t          wr_ent
);
  tlb_ent_t        ent_q [N];
  logic [PW-1:0]   wptr;

  // full compare; the lowest matching slot wins
  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ent_hit(ent_q[i], lk_vpn, lk_asid)) begin
        hit     = 1'b1;
        hit_ent = ent_q[i];
      end
    end
  end

  tlb_rr_ptr #(.N(N)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .ptr(wptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wptr] <= wr_ent;
    end
  end
endmodule

// File: rtl/tlb_joint.sv
module tlb_joint
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WPW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  input  pg_size_e          pr_size,
  output logic              hit,
  output tlb_ent_t          hit_ent,
  input  logic              wr_en,
  input  tlb_ent_t          wr_ent
);
  tlb_ent_t          arr [SETS][WAYS];
  logic [WPW-1:0]    wptr [SETS];
  logic [IDX_W-1:0]  pset;
  logic [IDX_W-1:0]  wset;

  // set index sits just above the offset of the probed page size
  function automatic logic [IDX_W-1:0] idx_of(logic [VPN_W-1:0] v, pg_size_e s);
    case (s)
      PG_2M:   return v[LVL_W +: IDX_W];
      PG_1G:   return v[2*LVL_W +: IDX_W];
      default: return v[0 +: IDX_W];
    endcase
  endfunction

  assign pset = idx_of(pr_vpn, pr_size);
  assign wset = idx_of(wr_ent.vpn, wr_ent.size);

  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (ent_hit(arr[pset][w], pr_vpn, pr_asid) &&
          (arr[pset][w].size == pr_size)) begin
        hit     = 1'b1;
        hit_ent = arr[pset][w];
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set_rr
    tlb_rr_ptr #(.N(WAYS)) u_rr (
      .clk(clk), .rst_n(rst_n),
      .adv(wr_en && (wset == IDX_W'(s))),
      .ptr(wptr[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          arr[s][w] <= '0;
    end else if (wr_en) begin
      arr[wset][wptr[wset]] <= wr_ent;
    end
  end
endmodule

// File: rtl/tlb_lookup_seq.sv
module tlb_lookup_seq
  import tlb_pkg::*;
#(
  parameter int UTLB_N    = 4,
  parameter int JTLB_SETS = 16,
  parameter int JTLB_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_size,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [VA_W-1:0]   walk_va,
  output logic [ASID_W-1:0] walk_asid,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_size
);
  typedef enum logic [2:0] {
    S_IDLE, S_UTLB, S_J4K, S_J2M, S_J1G, S_WALK, S_FILL, S_RESP
  } seq_st_e;

  seq_st_e            st;
  logic [VA_W-1:0]    va_q;
  logic [ASID_W-1:0]  asid_q;
  logic [PA_W-1:0]    pa_q;
  pg_size_e           size_q;

  logic [VPN_W-1:0]   vpn_q;
  logic               u_hit, j_hit;
  tlb_ent_t           u_ent, j_ent, fill_ent, u_wr_ent;
  pg_size_e           probe_sz;
  logic               in_probe, u_wr, j_wr, fill_take;

  assign vpn_q = va_q[VA_W-1:OFF_W];

  always_comb begin
    case (st)
      S_J2M:   probe_sz = PG_2M;
      S_J1G:   probe_sz = PG_1G;
      default: probe_sz = PG_4K;
    endcase
  end

  assign in_probe  = (st == S_J4K) || (st == S_J2M) || (st == S_J1G);
  assign fill_take = (st == S_FILL) && fill_valid;

  always_comb begin
    fill_ent      = '0;
    fill_ent.vld  = 1'b1;
    fill_ent.size = pg_size_e'(fill_size);
    fill_ent.asid = asid_q;
    fill_ent.vpn  = vpn_q;
    fill_ent.ppn  = fill_ppn;
  end

  assign u_wr     = (in_probe && j_hit) || fill_take;
  assign u_wr_ent = fill_take ? fill_ent : j_ent;
  assign j_wr     = fill_take;

  tlb_micro #(.N(UTLB_N)) u_micro (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(vpn_q), .lk_asid(asid_q),
    .hit(u_hit), .hit_ent(u_ent),
    .wr_en(u_wr), .wr_ent(u_wr_ent)
  );

  tlb_joint #(.SETS(JTLB_SETS), .WAYS(JTLB_WAYS)) u_joint (
    .clk(clk), .rst_n(rst_n),
    .pr_vpn(vpn_q), .pr_asid(asid_q), .pr_size(probe_sz),
    .hit(j_hit), .hit_ent(j_ent),
    .wr_en(j_wr), .wr_ent(fill_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      asid_q <= '0;
      pa_q   <= '0;
      size_q <= PG_4K;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          asid_q <= req_asid;
          st     <= S_UTLB;
        end
        S_UTLB: if (u_hit) begin
          pa_q   <= xlate(u_ent, va_q);
          size_q <= u_ent.size;
          st     <= S_RESP;
        end else begin
          st     <= S_J4K;
        end
        S_J4K, S_J2M, S_J1G: if (j_hit) begin
          pa_q   <= xlate(j_ent, va_q);
          size_q <= j_ent.size;
          st     <= S_RESP;
        end else begin
          st     <= (st == S_J4K) ? S_J2M : (st == S_J2M) ? S_J1G : S_WALK;
        end
        S_WALK: if (walk_ready) st <= S_FILL;
        S_FILL: if (fill_valid) begin
          pa_q   <= xlate(fill_ent, va_q);
          size_q <= fill_ent.size;
          st     <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RESP);
  assign rsp_pa     = pa_q;
  assign rsp_size   = size_q;
  assign walk_valid = (st == S_WALK);
  assign walk_va    = va_q;
  assign walk_asid  = asid_q;
  assign fill_ready = (st == S_FILL);
endmodule

// File: rtl/tlb_lookup_seq_chk.sv
module tlb_lookup_seq_chk
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_pa,
  input logic [1:0]        rsp_size,
  input logic              walk_valid,
  input logic              walk_ready,
  input logic [VA_W-1:0]   walk_va,
  input logic [ASID_W-1:0] walk_asid,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [1:0]        fill_size
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || walk_valid || fill_ready) |-> !req_ready);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_size));

  a_r5_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && !walk_ready |=> walk_valid && $stable(walk_va) && $stable(walk_asid));

  a_r5_walk_rsp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_valid && rsp_valid));

  a_r6_fill_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && walk_ready |=> fill_ready);

  a_r6_fill_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> rsp_valid && (rsp_size == $past(fill_size)));

  a_r8_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_size != 2'd3);
endmodule

bind tlb_lookup_seq tlb_lookup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_pa(rsp_pa), .rsp_size(rsp_size),
  .walk_valid(walk_valid), .walk_ready(walk_ready),
  .walk_va(walk_va), .walk_asid(walk_asid),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_size(fill_size)
);

// File: tb/sim_tlb_lookup_seq.sv
module sim_tlb_lookup_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [38:0] req_va = '0;
  logic [15:0] req_asid = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [39:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic        walk_valid, walk_ready = 1'b0;
  logic [38:0] walk_va;
  logic [15:0] walk_asid;
  logic        fill_valid = 1'b0, fill_ready;
  logic [27:0] fill_ppn = '0;
  logic [1:0]  fill_size = '0;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] ASID_A = 16'h00A5;
  localparam logic [15:0] ASID_B = 16'h0B17;

  always #2 clk = ~clk;

  tlb_lookup_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va), .walk_asid(walk_asid),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_ppn(fill_ppn), .fill_size(fill_size)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected address per R8: low 12/21/30 bits from va, rest from frame number
  function automatic logic [39:0] pa_of(logic [38:0] va, logic [27:0] ppn, logic [1:0] sz);
    logic [39:0] keep;
    keep = (40'd1 << (12 + 9 * sz)) - 40'd1;
    return ({ppn, 12'h000} & ~keep) | ({1'b0, va} & keep);
  endfunction

  // one lookup; the walker stub answers with fppn/fsize if a walk appears
  task automatic lookup(input logic [38:0] va, input logic [15:0] asid,
                        input logic [27:0] fppn, input logic [1:0] fsize,
                        input int exp_n, input bit exp_walk,
                        input logic [39:0] exp_pa, input logic [1:0] exp_sz,
                        input int rdly, input int wdly, input string tag);
    int n;
    bit busy_ok;
    logic [39:0] pa0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 idle ready", req_ready, 1);
    req_valid = 1'b1; req_va = va; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    busy_ok = 1'b1;
    while (!rsp_valid && !walk_valid && n < 12) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n == exp_n && walk_valid == exp_walk, tag, {n[31:0], 31'd0, walk_valid}, {exp_n[31:0], 31'd0, exp_walk});
    if (walk_valid) begin
      chk(walk_va == va && walk_asid == asid, "R5 walk fields", {walk_asid, 9'd0, walk_va}, {asid, 9'd0, va});
      for (int i = 0; i < wdly; i++) begin
        @(negedge clk);
        chk(walk_valid && walk_va == va, "R12 walk held", {63'd0, walk_valid}, 1);
      end
      walk_ready = 1'b1;
      @(negedge clk);
      walk_ready = 1'b0;
      chk(fill_ready === 1'b1, "R6 fill ready", fill_ready, 1);
      fill_valid = 1'b1; fill_ppn = fppn; fill_size = fsize;
      @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid === 1'b1, "R6 response after fill", rsp_valid, 1);
    end
    if (req_ready) busy_ok = 1'b0;
    chk(rsp_pa == exp_pa, "R8 address", rsp_pa, exp_pa);
    chk(rsp_size == exp_sz, "R8 size", rsp_size, exp_sz);
    pa0 = rsp_pa;
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == pa0 && !req_ready, "R12 response held", rsp_pa, pa0);
    end
    chk(busy_ok, "R2 busy while in flight", busy_ok, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R2 ready after response", {req_ready, rsp_valid}, 2'b10);
  endtask

  localparam logic [38:0] VA1 = 39'h00_1234_5678;
  localparam logic [38:0] VA2 = 39'h00_8020_1234;
  localparam logic [38:0] VA3 = 39'h0C_1234_5678;
  localparam logic [27:0] PPN1 = 28'h00ABCDE;
  localparam logic [27:0] PPN2 = 28'h0055555;
  localparam logic [27:0] PPN3 = 28'h0000400;
  localparam logic [27:0] PPN4 = 28'h0040000;

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid === 1'b0 && walk_valid === 1'b0 && fill_ready === 1'b0,
        "R1 idle outputs", {rsp_valid, walk_valid, fill_ready}, 0);
  endtask

  task automatic t_cold_miss;
    lookup(VA1, ASID_A, PPN1, 2'd0, 4, 1'b1, pa_of(VA1, PPN1, 0), 2'd0, 0, 0, "R1 cold walk");
  endtask

  task automatic t_front_hit;
    lookup(VA1 ^ 39'h0FF, ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(VA1 ^ 39'h0FF, PPN1, 0), 2'd0, 0, 0, "R3 front hit");
  endtask

  task automatic t_asid;
    lookup(VA1, ASID_B, PPN2, 2'd0, 4, 1'b1, pa_of(VA1, PPN2, 0), 2'd0, 0, 0, "R9 other asid walks");
    lookup(VA1, ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(VA1, PPN1, 0), 2'd0, 0, 0, "R9 own asid keeps");
  endtask

  task automatic fillers(input int k0);
    for (int k = k0; k < k0 + 4; k++) begin
      logic [38:0] fv;
      fv = 39'h10_0000_0000 + 39'(k << 12);
      lookup(fv, ASID_A, 28'h0100000 + 28'(k), 2'd0, 4, 1'b1,
             pa_of(fv, 28'h0100000 + 28'(k), 0), 2'd0, 0, 0, "R5 filler walk");
    end
  endtask

  task automatic t_2m;
    logic [38:0] v;
    lookup(VA2, ASID_A, PPN3, 2'd1, 4, 1'b1, pa_of(VA2, PPN3, 1), 2'd1, 0, 0, "R5 2M walk");
    fillers(8);
    v = VA2 ^ 39'h1F000;
    // R10: front copy evicted after four installs, found by the 2M probe
    lookup(v, ASID_A, 28'h0, 2'd0, 3, 1'b0, pa_of(v, PPN3, 1), 2'd1, 0, 0, "R4 2M probe latency");
    lookup(v, ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(v, PPN3, 1), 2'd1, 0, 0, "R7 copy after 2M hit");
  endtask

  task automatic t_1g;
    logic [38:0] v;
    lookup(VA3, ASID_A, PPN4, 2'd2, 4, 1'b1, pa_of(VA3, PPN4, 2), 2'd2, 0, 0, "R5 1G walk");
    fillers(12);
    v = VA3 ^ 39'h0_0ABC_0000;
    lookup(v, ASID_A, 28'h0, 2'd0, 4, 1'b0, pa_of(v, PPN4, 2), 2'd2, 0, 0, "R4 1G probe latency");
    lookup(v, ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(v, PPN4, 2), 2'd2, 0, 0, "R7 copy after 1G hit");
  endtask

  function automatic logic [38:0] qva(int k);
    return 39'h20_0000_3000 + 39'(k << 16);
  endfunction

  task automatic t_replace;
    for (int k = 0; k < 5; k++)
      lookup(qva(k), ASID_A, 28'h0200000 + 28'(k), 2'd0, 4, 1'b1,
             pa_of(qva(k), 28'h0200000 + 28'(k), 0), 2'd0, 0, 0, "R11 set fill");
    lookup(qva(1), ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(qva(1), 28'h0200001, 0), 2'd0, 0, 0, "R10 recent kept");
    lookup(qva(0), ASID_A, 28'h0200000, 2'd0, 4, 1'b1, pa_of(qva(0), 28'h0200000, 0), 2'd0, 0, 0, "R10 oldest evicted");
    lookup(qva(1), ASID_A, 28'h0200001, 2'd0, 4, 1'b1, pa_of(qva(1), 28'h0200001, 0), 2'd0, 0, 0, "R11 round-robin victim");
  endtask

  task automatic t_backpressure;
    lookup(qva(4), ASID_A, 28'h0, 2'd0, 1, 1'b0, pa_of(qva(4), 28'h0200004, 0), 2'd0, 3, 0, "R12 rsp stall");
    lookup(39'h30_0000_7000, ASID_A, 28'h0300000, 2'd0, 4, 1'b1,
           pa_of(39'h30_0000_7000, 28'h0300000, 0), 2'd0, 2, 3, "R12 walk stall");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_front_hit();
    t_asid();
    t_2m();
    t_1g();
    t_replace();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule